// File: doc/BRIEF.md
# Byte/Word Parallel ROM Read Controller

This block sits between a synchronous host and an asynchronous parallel mask ROM that can be strapped per access as 1M x 16 or 2M x 8. The host presents a request with an address and a mode flag. The controller then drives the chip-enable, output-enable, width-select and address pins. It holds them for a fixed number of clock cycles, which covers the ROM's access times and its minimum cycle time. It then latches the data bus and returns the result with a one-cycle valid strobe.

In byte mode the ROM's top data pin turns into an input that carries the least significant address bit. The controller drives that pin only once the ROM has had time to release it after any earlier word-mode read. The returned byte is zero-extended. All delays are given in nanoseconds and converted to clock counts by ceiling division against the clock period. Between reads the ROM is kept in standby. The exception is a request that arrives on the last cycle of a read: it starts at once and chip enable stays asserted.

Top module: `prom_reader`

## Requirements
- R1: During reset and whenever the controller is idle, `rom_ce_n` and `rom_oe_n` are 1, `rom_d15_oe` is 0, `ready` is 1 and `rvalid` is 0.
- R2: A request with `req_byte`=0 is a word read. It sets `rom_word`=1, drives `rom_addr` with `req_addr[19:0]` and returns all 16 bits of `rom_d_in` on `rdata`.
- R3: A request with `req_byte`=1 is a byte read. It sets `rom_word`=0, drives `rom_addr` with `req_addr[20:1]` and drives `req_addr[0]` on `rom_d15_out` with `rom_d15_oe`=1. It returns `{8'h00, rom_d_in[7:0]}` on `rdata`; bits 15..8 of `rom_d_in` are ignored.
- R4: Data is captured after ACC_CYC = max(ceil(150/Tclk), ceil(50/Tclk)) cycles with the ROM enabled and the address steady, where 150 ns covers both the access time and the minimum cycle time. That is 8 cycles at 20 ns. `rvalid` is high for exactly one cycle, ACC_CYC clock edges after the accepting edge.
- R5: A request is taken only when `ready` is 1, which holds in idle and on the last cycle of a read. While a read is in progress, the address, width select and D15 output stay steady, and requests are ignored.
- R6: `rom_d15_oe` is asserted only in byte mode and only after at least FLT_CYC = max(ceil(50/Tclk), ceil(30/Tclk)) cycles have passed since the last cycle in which the ROM was enabled in word mode. A byte read that follows too soon waits with chip enable high.
- R7: A request accepted on the last cycle of a read starts a new read without raising `rom_ce_n`. Otherwise `rom_ce_n` returns to 1 at the end of the read.
- R8: `rom_oe_n` always equals `rom_ce_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Read request |
| req_byte | input | 1 | 1 = byte read, 0 = word read |
| req_addr | input | 21 | Byte address (byte mode) or word address in bits 19..0 (word mode) |
| ready | output | 1 | Request accepted on this cycle if `req` is high |
| rdata | output | 16 | Read result |
| rvalid | output | 1 | One-cycle strobe: `rdata` is valid |
| rom_ce_n | output | 1 | ROM chip enable, active low |
| rom_oe_n | output | 1 | ROM output enable, active low |
| rom_word | output | 1 | ROM width select, 1 = 16-bit |
| rom_addr | output | 20 | ROM address pins |
| rom_d15_out | output | 1 | Value driven onto the shared D15 pin in byte mode |
| rom_d15_oe | output | 1 | Host drive enable for the shared D15 pin |
| rom_d_in | input | 16 | ROM data bus as seen by the host |

## Verification
A miscounted access timer shows up as a wrong `rvalid` position or as garbage data. The bench's ROM model returns a poison pattern until every access window has elapsed, so a short count fails on the very first read. A lane or mapping error shows as a wrong `rdata` value on the first byte read of the affected lane. A guard counter that clears too early shows as a D15 contention flag, raised within one read after a word-to-byte switch. A state machine that leaves the ROM enabled is caught at the ports in the first idle cycle, and one that drops chip enable during a chained read is caught in the first cycle it does so.

// File: rtl/prom_reader_pkg.sv
`timescale 1ns/1ps
package prom_reader_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_ACCESS = 2'd2
  } rd_state_e;

  // ceiling division used to turn nanosecond limits into clock counts
  function automatic int cdiv(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/prom_step_cnt.sv
`timescale 1ns/1ps
// Up-counter with synchronous clear and explicit count enable.
module prom_step_cnt #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  output logic [W-1:0] q
);

  logic [W-1:0] q_d;

  always_comb begin
    q_d = q;
    if (clr)     q_d = '0;
    else if (en) q_d = q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         q <= '0;
    else if (clr || en) q <= q_d;
  end

endmodule

// File: rtl/prom_float_guard.sv
`timescale 1ns/1ps
// Reloads whenever the ROM may be driving D15, then counts down.
// clear = the pin has had long enough to float.
module prom_float_guard #(
  parameter int N = 3,
  parameter int W = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic clear
);

  logic [W-1:0] left_q, left_d;

  always_comb begin
    left_d = left_q;
    if (load)               left_d = W'(N);
    else if (left_q != '0)  left_d = left_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) left_q <= '0;
    else        left_q <= left_d;
  end

  assign clear = (left_q == '0);

endmodule

// File: rtl/prom_reader.sv
`timescale 1ns/1ps
module prom_reader
  import prom_reader_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 20,
  parameter int T_ACC_NS      = 150,
  parameter int T_OE_NS       = 50,
  parameter int T_CYC_NS      = 150,
  parameter int T_FLT_NS      = 50,
  parameter int T_BFLT_NS     = 30,
  parameter int AW            = 20,
  parameter int DW            = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          req_byte,
  input  logic [AW:0]   req_addr,
  output logic          ready,
  output logic [DW-1:0] rdata,
  output logic          rvalid,
  output logic          rom_ce_n,
  output logic          rom_oe_n,
  output logic          rom_word,
  output logic [AW-1:0] rom_addr,
  output logic          rom_d15_out,
  output logic          rom_d15_oe,
  input  logic [DW-1:0] rom_d_in
);

  localparam int ACC_CYC = imax(imax(cdiv(T_ACC_NS, CLK_PERIOD_NS), cdiv(T_OE_NS, CLK_PERIOD_NS)),
                                imax(cdiv(T_CYC_NS, CLK_PERIOD_NS), 2));
  localparam int FLT_CYC = imax(imax(cdiv(T_FLT_NS, CLK_PERIOD_NS), cdiv(T_BFLT_NS, CLK_PERIOD_NS)), 1);
  localparam int CW      = $clog2(ACC_CYC + 1);
  localparam int GW      = $clog2(FLT_CYC + 1);
  localparam int BW      = DW / 2;

  rd_state_e     st_q, st_d;
  logic [CW-1:0] cnt;
  logic          cnt_clr, cnt_en, cnt_done;
  logic          flt_clear, drv_now, accept, go_setup, capture;
  logic          ce_n_d, oe_n_d, word_d, d15_d, d15_oe_d;
  logic [AW-1:0] addr_d;
  logic [DW-1:0] cap_data;

  // ROM may be driving its D15 pin this cycle
  assign drv_now  = !rom_ce_n && !rom_oe_n && rom_word;
  assign cnt_done = (st_q == ST_ACCESS) && (cnt == CW'(ACC_CYC - 1));
  assign ready    = (st_q == ST_IDLE) || cnt_done;
  assign accept   = req && ready;
  assign go_setup = req_byte && (drv_now || !flt_clear);
  assign capture  = cnt_done;
  assign cnt_en   = (st_q == ST_ACCESS) && !cnt_done;

  prom_step_cnt #(.W(CW)) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (cnt_clr),
    .en   (cnt_en),
    .q    (cnt)
  );

  prom_float_guard #(.N(FLT_CYC), .W(GW)) u_guard (
    .clk  (clk),
    .rst_n(rst_n),
    .load (drv_now),
    .clear(flt_clear)
  );

  // next-state and next-output logic
  always_comb begin
    st_d     = st_q;
    ce_n_d   = rom_ce_n;
    oe_n_d   = rom_oe_n;
    word_d   = rom_word;
    addr_d   = rom_addr;
    d15_d    = rom_d15_out;
    d15_oe_d = rom_d15_oe;
    cnt_clr  = 1'b0;

    case (st_q)
      ST_SETUP: begin
        if (flt_clear) begin
          st_d     = ST_ACCESS;
          ce_n_d   = 1'b0;
          oe_n_d   = 1'b0;
          d15_oe_d = 1'b1;
          cnt_clr  = 1'b1;
        end
      end
      ST_ACCESS: begin
        if (cnt_done) begin
          st_d     = ST_IDLE;
          ce_n_d   = 1'b1;
          oe_n_d   = 1'b1;
          d15_oe_d = 1'b0;
        end
      end
      default: ;
    endcase

    if (accept) begin
      word_d  = !req_byte;
      addr_d  = req_byte ? req_addr[AW:1] : req_addr[AW-1:0];
      d15_d   = req_byte & req_addr[0];
      cnt_clr = 1'b1;
      if (go_setup) begin
        st_d     = ST_SETUP;
        ce_n_d   = 1'b1;
        oe_n_d   = 1'b1;
        d15_oe_d = 1'b0;
      end else begin
        st_d     = ST_ACCESS;
        ce_n_d   = 1'b0;
        oe_n_d   = 1'b0;
        d15_oe_d = req_byte;
      end
    end
  end

  assign cap_data = rom_word ? rom_d_in : {{(DW-BW){1'b0}}, rom_d_in[BW-1:0]};

  // control and pin registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      rom_ce_n    <= 1'b1;
      rom_oe_n    <= 1'b1;
      rom_word    <= 1'b1;
      rom_addr    <= '0;
      rom_d15_out <= 1'b0;
      rom_d15_oe  <= 1'b0;
      rvalid      <= 1'b0;
    end else begin
      st_q        <= st_d;
      rom_ce_n    <= ce_n_d;
      rom_oe_n    <= oe_n_d;
      rom_word    <= word_d;
      rom_addr    <= addr_d;
      rom_d15_out <= d15_d;
      rom_d15_oe  <= d15_oe_d;
      rvalid      <= capture;
    end
  end

  // result register, enabled only on capture
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata <= '0;
    else if (capture) rdata <= cap_data;
  end

endmodule

// File: rtl/prom_reader_chk.sv
`timescale 1ns/1ps
module prom_reader_chk #(
  parameter int AW      = 20,
  parameter int ACC_CYC = 8,
  parameter int FLT_CYC = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ready,
  input logic          rvalid,
  input logic          rom_ce_n,
  input logic          rom_oe_n,
  input logic          rom_word,
  input logic [AW-1:0] rom_addr,
  input logic          rom_d15_out,
  input logic          rom_d15_oe
);

  logic [7:0]    since_q, run_q, run_now;
  logic [AW-1:0] addr_p;
  logic          ce_p, word_p, a1_p, same;

  // cycles since ROM last had its outputs on in word mode
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               since_q <= 8'(FLT_CYC);
    else if (!rom_ce_n && !rom_oe_n && rom_word) since_q <= 8'd0;
    else if (since_q < 8'(FLT_CYC))           since_q <= since_q + 8'd1;
  end

  assign same    = !rom_ce_n && !ce_p && (rom_addr == addr_p) &&
                   (rom_word == word_p) && (rom_d15_out == a1_p);
  assign run_now = rom_ce_n ? 8'd0 : (same ? ((run_q == 8'hFF) ? run_q : run_q + 8'd1) : 8'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 8'd0;
      addr_p <= '0;
      ce_p   <= 1'b1;
      word_p <= 1'b1;
      a1_p   <= 1'b0;
    end else begin
      run_q  <= run_now;
      addr_p <= rom_addr;
      ce_p   <= rom_ce_n;
      word_p <= rom_word;
      a1_p   <= rom_d15_out;
    end
  end

  assert_standby_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rom_ce_n |-> !rom_d15_oe);

  assert_hold_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!rom_ce_n && ready) |-> (run_now >= 8'(ACC_CYC)));

  assert_single_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |=> !rvalid);

  assert_busy_steady_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!rom_ce_n && !ready) |=> ($stable(rom_addr) && $stable(rom_word) && $stable(rom_d15_out)));

  assert_pin_turnaround_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rom_d15_oe |-> (!rom_word && (since_q >= 8'(FLT_CYC))));

  assert_strobe_pair_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rom_oe_n == rom_ce_n);

endmodule

bind prom_reader prom_reader_chk #(
  .AW(AW), .ACC_CYC(ACC_CYC), .FLT_CYC(FLT_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ready(ready), .rvalid(rvalid),
  .rom_ce_n(rom_ce_n), .rom_oe_n(rom_oe_n), .rom_word(rom_word),
  .rom_addr(rom_addr), .rom_d15_out(rom_d15_out), .rom_d15_oe(rom_d15_oe)
);

// File: tb/prom_reader_tb.sv
`timescale 1ns/1ps
module prom_reader_tb;

  localparam int ACC = 8;   // ceil(150/20)
  localparam int LAT = ACC + 1;

  logic        clk, rst_n, req, req_byte;
  logic [20:0] req_addr;
  logic        ready, rvalid, rom_ce_n, rom_oe_n, rom_word, rom_d15_out, rom_d15_oe;
  logic [15:0] rdata, rom_d_in;
  logic [19:0] rom_addr;

  int  n_chk, n_fail;
  bit  contention;
  longint t_a, t_c, t_o, t_off;

  prom_reader u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .req_byte(req_byte), .req_addr(req_addr),
    .ready(ready), .rdata(rdata), .rvalid(rvalid), .rom_ce_n(rom_ce_n),
    .rom_oe_n(rom_oe_n), .rom_word(rom_word), .rom_addr(rom_addr),
    .rom_d15_out(rom_d15_out), .rom_d15_oe(rom_d15_oe), .rom_d_in(rom_d_in)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // ---------------- behavioural ROM ----------------
  function automatic logic [15:0] mem_word(input logic [19:0] a);
    return (a[15:0] * 16'h2F1B) ^ {a[19:16], a[11:0]} ^ 16'h6C3A;
  endfunction

  function automatic logic [7:0] mem_byte(input logic [20:0] b);
    logic [15:0] w;
    w = mem_word(b[20:1]);
    return b[0] ? w[15:8] : w[7:0];
  endfunction

  initial begin
    t_a = 0; t_c = 0; t_o = 0; t_off = -1000; contention = 0;
    rom_d_in = 16'hFFFF;
  end

  always @(rom_addr or rom_word or rom_d15_out or rom_d15_oe) t_a = $time;
  always @(rom_ce_n) t_c = $time;
  always @(rom_oe_n) t_o = $time;

  initial forever begin
    longint now;
    bit en, ok;
    #1;
    now = $time;
    en  = !rom_ce_n && !rom_oe_n;
    ok  = en && (now - t_a >= 150) && (now - t_c >= 150) && (now - t_o >= 50);
    if (en && rom_word) t_off = now;
    if (rom_d15_oe && (rom_word || (now - t_off <= 50))) contention = 1;
    if (!en) rom_d_in = 16'hFFFF;
    else if (rom_word) rom_d_in = ok ? mem_word(rom_addr) : 16'hBAD1;
    else rom_d_in = {rom_d15_oe ? rom_d15_out : 1'b1, 7'h7F,
                     (ok && rom_d15_oe) ? mem_byte({rom_addr, rom_d15_out}) : 8'hA5};
  end

  // ---------------- check helper ----------------
  task automatic check(input bit cond, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", rq, what, act, exp);
    end
  endtask

  task automatic do_read(input logic [20:0] a, input bit bm, output int lat, output logic [15:0] d);
    @(negedge clk);
    req_addr = a; req_byte = bm; req = 1'b1;
    while (!ready) @(negedge clk);
    @(negedge clk);
    req = 1'b0;
    lat = 1;
    while (!rvalid && lat < 60) begin @(negedge clk); lat++; end
    d = rdata;
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    rst_n = 1'b0; req = 1'b0; req_byte = 1'b0; req_addr = '0;
    repeat (3) @(negedge clk);
    check(rom_ce_n && rom_oe_n, "R1", "strobes in reset", {rom_ce_n, rom_oe_n}, 2'b11);
    check(!rom_d15_oe && !rvalid, "R1", "d15/rvalid in reset", {rom_d15_oe, rvalid}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(ready && rom_ce_n && !rvalid, "R1", "idle after reset", {ready, rom_ce_n, rvalid}, 3'b110);
  endtask

  task automatic t_word_reads();
    logic [20:0] addrs [3] = '{21'h000000, 21'h0FFFFF, 21'h05A3C7};
    foreach (addrs[i]) begin
      int lat; logic [15:0] d;
      do_read(addrs[i], 1'b0, lat, d);
      check(d == mem_word(addrs[i][19:0]), "R2", "word data", d, mem_word(addrs[i][19:0]));
      check(lat == LAT, "R4", "word latency", lat, LAT);
      @(negedge clk);
      check(!rvalid, "R4", "rvalid one cycle", rvalid, 0);
    end
  endtask

  task automatic t_byte_lanes();
    logic [20:0] addrs [4] = '{21'h000002, 21'h000003, 21'h1ABCDE, 21'h1ABCDF};
    repeat (6) @(negedge clk);  // let any word-mode float time pass
    foreach (addrs[i]) begin
      int lat; logic [15:0] d;
      do_read(addrs[i], 1'b1, lat, d);
      check(d == {8'h00, mem_byte(addrs[i])}, "R3", "byte data zero-extended", d, {8'h00, mem_byte(addrs[i])});
      check(lat == LAT, "R4", "byte latency", lat, LAT);
    end
  endtask

  task automatic t_turnaround();
    int lat; logic [15:0] d;
    do_read(21'h012345, 1'b0, lat, d);
    check(d == mem_word(20'h12345), "R2", "word before switch", d, mem_word(20'h12345));
    do_read(21'h0ACE01, 1'b1, lat, d);
    check(d == {8'h00, mem_byte(21'h0ACE01)}, "R3", "byte after word", d, {8'h00, mem_byte(21'h0ACE01)});
    check(lat > LAT, "R6", "byte after word waits for float", lat, LAT + 1);
    check(!contention, "R6", "no D15 contention", contention, 0);
  endtask

  task automatic t_back_to_back();
    int got; bit ce_hi, pair_bad; logic [15:0] d0, d1;
    got = 0; ce_hi = 0; pair_bad = 0; d0 = '0; d1 = '0;
    @(negedge clk);
    req_addr = 21'h00F00D; req_byte = 1'b0; req = 1'b1;
    while (!ready) @(negedge clk);
    @(negedge clk);
    req_addr = 21'h0BEEF0;
    while (!ready) @(negedge clk);
    @(negedge clk);
    req = 1'b0;
    for (int k = 0; k < 40 && got < 2; k++) begin
      if (rom_oe_n != rom_ce_n) pair_bad = 1;
      if (rvalid) begin
        if (got == 0) d0 = rdata; else d1 = rdata;
        got++;
      end else if (rom_ce_n) ce_hi = 1;
      if (got < 2) @(negedge clk);
    end
    check(got == 2, "R7", "two strobes", got, 2);
    check(!ce_hi, "R7", "ce held low across chained reads", ce_hi, 0);
    check(d0 == mem_word(20'h0F00D) && d1 == mem_word(20'hBEEF0), "R7", "chained data",
          {d0, d1}, {mem_word(20'h0F00D), mem_word(20'hBEEF0)});
    check(!pair_bad, "R8", "oe tracks ce", pair_bad, 0);
  endtask

  task automatic t_busy_ignore();
    int strobes; bit moved; logic [15:0] d;
    strobes = 0; moved = 0; d = '0;
    @(negedge clk);
    req_addr = 21'h033333; req_byte = 1'b0; req = 1'b1;
    while (!ready) @(negedge clk);
    @(negedge clk);
    req = 1'b0;
    for (int k = 2; k < 30; k++) begin
      @(negedge clk);
      if (k >= 2 && k <= 5) begin req = 1'b1; req_byte = 1'b1; req_addr = 21'(21'h1F0000 + k); end
      else req = 1'b0;
      if (!rom_ce_n && (rom_addr != 20'h33333 || !rom_word)) moved = 1;
      if (rvalid) begin strobes++; d = rdata; end
    end
    check(!moved, "R5", "pins steady while busy", moved, 0);
    check(strobes == 1 && d == mem_word(20'h33333), "R5", "busy request ignored", {strobes[15:0], d},
          {16'd1, mem_word(20'h33333)});
  endtask

  task automatic t_standby();
    bit bad;
    bad = 0;
    repeat (12) begin
      @(negedge clk);
      if (!rom_ce_n || !rom_oe_n || rom_d15_oe || rvalid || !ready) bad = 1;
    end
    check(!bad, "R1", "standby isolation while idle", bad, 0);
  endtask

  // ---------------- main and watchdog ----------------
  initial begin
    n_chk = 0; n_fail = 0;
    t_reset();
    t_word_reads();
    t_byte_lanes();
    t_turnaround();
    t_back_to_back();
    t_busy_ignore();
    t_standby();
    check(!contention, "R6", "no D15 contention over run", contention, 0);
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #4000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule